// File: doc/BRIEF.md
# Addressed Serial DAC Register Interface

This block is a three-wire serial front end for an eight-channel DAC. A 16-bit frame enters on the serial data input, one bit per rising clock edge, while the load line is held high. The frame holds a 4-bit channel address followed by a 12-bit code. The most significant bit of the shift register drives the serial output, so several devices can be daisy-chained.

When the load line drops, the captured code is committed to the holding register of the addressed channel. Address values from eight upward commit nothing. While the load line stays low, the shift register ignores the serial input and the clock, and the serial output enable is deasserted. An asynchronous active-low reset clears the shift register and all eight holding registers. The register contents leave the block as a flat digital bus. Analog conversion is handled elsewhere.

Top module: `dac_ser_if`

## Requirements
- R1: The first bit shifted in lands in the top of the 16-bit frame. After 16 shifts the frame reads {A3..A0, DB11..DB0}: the address is in bits 15:12 and the code is in bits 11:0.
- R2: On each rising clock edge with load_i high, sdi_i enters bit 0 of the shift register and the contents move one place up. sdo_o is bit 15, so it repeats sdi_i delayed by 16 shifts.
- R3: sdo_oe_o equals load_i. High means sdo_o is driven; low means the output is high-impedance.
- R4: A falling edge of load_i is detected at the first rising clock edge that samples load_i low after sampling it high. The 12-bit code is written into the addressed channel at the next rising edge. It is not visible on ch_code_o before then.
- R5: Addresses 0 to 7 select channels 0 to 7. Channel n occupies ch_code_o[12n+11:12n].
- R6: Addresses 8 to 15 (A3 set) change no channel register.
- R7: While load_i is low, sdi_i and clock edges leave the shift register unchanged. The contents are kept and continue shifting out once load_i rises again.
- R8: When rst_ni is low, all channel registers and the shift register are cleared at once, whatever the other inputs are doing. sdo_o then reads 0.
- R9: A write changes only the addressed channel. All other channels keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | High: shift enabled. Falling edge: commit. Low: idle |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdo_o | output | 1 | Serial data out (top bit of the shift register) |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| ch_code_o | output | 96 | Eight 12-bit channel codes, channel 0 in the low bits |

## Verification
The bench drives inputs on the falling clock edge and samples one half-cycle later. sdo_o is checked before every shift against the bench's own frame model, so each value is checked one edge after the shift that produced it. sdo_oe_o is purely combinational and is checked 1 ns after load_i changes. A commit needs two rising edges after load_i drops, one to detect the edge and one to write. The bench therefore checks that the channels still hold their old values after the first edge and the new code after the second. Reset is checked 1 ns after rst_ni falls, without waiting for any clock edge.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  localparam int ADDR_W_DEF = 4;
  localparam int DATA_W_DEF = 12;
  localparam int N_CH_DEF   = 8;

  // true when the address selects an existing channel
  function automatic logic addr_hits(input int unsigned addr, input int unsigned n_ch);
    return addr < n_ch;
  endfunction
endpackage

// File: rtl/dac_ser_shift.sv
module dac_ser_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '0;
    else if (load_i) frame_q <= {frame_q[FRAME_W-2:0], sdi_i};
  end

  assign frame_o = frame_q;
  assign sdo_o   = frame_q[FRAME_W-1];

  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> frame_q[0] == $past(sdi_i));
  p_shift_up_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0]));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(frame_q));
endmodule

// File: rtl/dac_ser_ctrl.sv
module dac_ser_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  localparam int FRAME_W = ADDR_W + DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o
);
  logic load_q;
  logic fall;

  assign fall = load_q & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      load_q  <= load_i;
      wr_en_o <= fall;
      if (fall) begin
        wr_addr_o <= frame_i[FRAME_W-1 -: ADDR_W];
        wr_data_o <= frame_i[DATA_W-1:0];
      end
    end
  end

  // a commit lasts one cycle, since the fall needs load high again to recur
  p_single_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  p_commit_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !load_q);
endmodule

// File: rtl/dac_ser_bank.sv
module dac_ser_bank
  import dac_ser_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter int N_CH   = 8,
  localparam int BUS_W = N_CH * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [BUS_W-1:0]  ch_code_o
);
  logic [DATA_W-1:0] regs_q [N_CH];
  logic [N_CH-1:0]   sel;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign sel[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_q[i] <= '0;
      else if (sel[i]) regs_q[i] <= wr_data_i;
    end

    assign ch_code_o[i*DATA_W +: DATA_W] = regs_q[i];

    p_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel[i] |=> ch_code_o[i*DATA_W +: DATA_W] == $past(wr_data_i));
    p_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel[i] |=> $stable(ch_code_o[i*DATA_W +: DATA_W]));
  end

  p_noop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_hits(int'(wr_addr_i), N_CH)) |=> $stable(ch_code_o));
endmodule

// File: rtl/dac_ser_if.sv
module dac_ser_if
  import dac_ser_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int N_CH   = N_CH_DEF,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int BUS_W   = N_CH * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [BUS_W-1:0] ch_code_o
);
  logic [FRAME_W-1:0] frame;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DATA_W-1:0]  wr_data;

  dac_ser_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .sdi_i   (sdi_i),
    .frame_o (frame),
    .sdo_o   (sdo_o)
  );

  dac_ser_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .frame_i   (frame),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  dac_ser_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CH(N_CH)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .ch_code_o (ch_code_o)
  );

  assign sdo_oe_o = load_i;

  p_oe_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |=> $stable(sdo_o));
endmodule

// File: tb/dac_ser_if_tb.sv
`timescale 1ns/1ps
module dac_ser_if_tb;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [NCH*DW-1:0] ch_code;

  int checks = 0;
  int errors = 0;
  logic [15:0]   model_sr = '0;
  logic [DW-1:0] exp_ch [NCH];

  always #4 clk = ~clk;

  dac_ser_if u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .load_i    (load),
    .sdi_i     (sdi),
    .sdo_o     (sdo),
    .sdo_oe_o  (sdo_oe),
    .ch_code_o (ch_code)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < NCH; i++)
      chk(ch_code[i*DW +: DW] === exp_ch[i], req, 32'(ch_code[i*DW +: DW]), 32'(exp_ch[i]));
  endtask

  // R1 R2 R3 R4 R5 R6 R9: shift one frame MSB first, then drop load
  task automatic send_frame(input logic [3:0] a, input logic [DW-1:0] d);
    logic [15:0] f;
    f = {a, d};
    for (int k = 15; k >= 0; k--) begin
      @(negedge clk);
      load = 1'b1;
      sdi  = f[k];
      #1;
      chk(sdo_oe === 1'b1, "R3 oe high", 32'(sdo_oe), 1);
      chk(sdo === model_sr[15], "R2 sdo", 32'(sdo), 32'(model_sr[15]));
      model_sr = {model_sr[14:0], f[k]};
    end
    @(negedge clk);
    load = 1'b0;
    sdi  = $urandom();
    #1;
    chk(sdo_oe === 1'b0, "R3 oe low", 32'(sdo_oe), 0);
    chk(sdo === a[3], "R1 top bit is A3", 32'(sdo), 32'(a[3]));
    @(negedge clk);
    chk_all("R4 not before second edge");
    if (a < 4'(NCH)) exp_ch[a[2:0]] = d;
    @(negedge clk);
    if (a < 4'(NCH)) chk_all("R5 R9 write");
    else             chk_all("R6 no-op address");
  endtask

  // R7: noise on sdi with load low
  task automatic idle_noise(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sdi = $urandom();
    end
    #1;
    chk(sdo === model_sr[15], "R7 shift held", 32'(sdo), 32'(model_sr[15]));
    chk_all("R7 channels held");
  endtask

  initial begin
    void'($urandom(32'd7612));
    for (int i = 0; i < NCH; i++) exp_ch[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk_all("R8 reset state");
    chk(sdo === 1'b0, "R8 sdo reset", 32'(sdo), 0);
    chk(sdo_oe === 1'b0, "R3 oe reset", 32'(sdo_oe), 0);
    @(negedge clk);
    rst_n = 1'b1;

    send_frame(4'd0, 12'hFFF);
    send_frame(4'd7, 12'hA5C);
    send_frame(4'd8, 12'h123);
    send_frame(4'd15, 12'hFFF);
    send_frame(4'd3, 12'h000);
    idle_noise(5);
    send_frame(4'd0, 12'h001);

    for (int n = 0; n < 40; n++) begin
      send_frame(4'($urandom_range(0, 15)), 12'($urandom()));
      idle_noise($urandom_range(0, 4));
    end

    // R8: reset mid-frame with load high
    @(negedge clk);
    load = 1'b1;
    sdi  = 1'b1;
    #2;
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < NCH; i++) exp_ch[i] = '0;
    model_sr = '0;
    chk_all("R8 async clear");
    chk(sdo === 1'b0, "R8 sdo clear", 32'(sdo), 0);
    @(posedge clk);
    #1;
    chk(sdo === 1'b0, "R8 held in reset", 32'(sdo), 0);
    @(negedge clk);
    load  = 1'b0;
    rst_n = 1'b1;
    send_frame(4'd5, 12'h6B1);
    send_frame(4'd4, 12'h0F0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule